// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs management transactions on a two-wire PHY management bus. The host asserts a one-cycle start strobe together with a direction select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then builds the whole 64-bit frame in hardware and shifts it out on the data line, one bit per management clock period. Each bit is set up while the management clock is low and is clocked by the rising edge that follows.

The management clock is derived from the system clock by a divider. One management period lasts 2×`CLK_DIV` system cycles, so the bus can run as fast as half the system clock. The data line is split into an output value, an output enable and an input. The master drives the line only while it owns it. During a read it releases the line for the turnaround and data fields, and it samples the PHY's 16 data bits on the rising clock edges.

Because the PHY address field selects the target, several PHYs can share one bus. At the end of a frame the block raises a single-cycle completion pulse. The read result stays on the read-data output until the next read finishes.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, busy, done, the management clock and the data output enable are all low.
- R2: While a frame runs, the management clock stays high for exactly `CLK_DIV` system cycles and low for exactly `CLK_DIV` system cycles. A frame therefore lasts 128×`CLK_DIV` system cycles.
- R3: An accepted start raises busy on the next cycle. Busy stays high through exactly 64 management clock pulses and drops at the falling edge of the last one. In that same cycle, done is high for exactly one system cycle.
- R4: Every frame opens with 32 consecutive ones on the data line.
- R5: A write frame sends, most-significant bit first, start/opcode 0101, then the 5-bit PHY address, then the 5-bit register address, then turnaround 10, then the 16 write-data bits. The output enable stays high for all 64 bits.
- R6: A read frame sends start/opcode 0110, then the PHY address, then the register address. The output enable is high for the first 46 bits and low for the last 18 (turnaround and data). The 16 data bits are sampled at the rising clock edges of bits 48..63, and the first sampled bit is the most significant. The result appears on the read-data output in the cycle that done is high.
- R7: A start strobe that arrives while busy is high is ignored. The running frame continues unchanged, and no second frame follows it.
- R8: The data line value and its output enable never change while the management clock is high.
- R9: The PHY address field selects the target on a shared bus. At least five PHYs at distinct addresses hold independent registers. A read from an address with no PHY returns 16'hFFFF because the line is pulled up.
- R10: The read-data output keeps the result of the last read. Write frames do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a frame; taken only when idle |
| read_i | input | 1 | 1 = read frame, 0 = write frame; captured at start |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write value |
| rdata_o | output | 16 | Result of the most recent read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The main instance is built with `CLK_DIV = 2`. This gives a divider with a real counter and a frame of 256 system cycles, which leaves room to inject a second start in the middle of a frame. A second instance is built with `CLK_DIV = 1`. That runs the fastest rate the block allows, with the clock at half the system rate and every half period one cycle long, so the degenerate divider branch and the one-cycle spacing between rise and fall events are both exercised. A behavioural model of five PHYs, plus a pull-up for unanswered reads, sits on the main instance's bus and checks the bit order and the line-release points.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 4;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int TA_BITS   = 2;
    localparam int DAT_W     = 16;

    localparam int FRAME_BITS  = PRE_BITS + HDR_BITS + PHY_W + REG_W + TA_BITS + DAT_W;
    localparam int CNT_W       = $clog2(FRAME_BITS);
    localparam int RELEASE_IDX = PRE_BITS + HDR_BITS + PHY_W + REG_W;
    localparam int DATA_IDX    = RELEASE_IDX + TA_BITS;

    localparam logic [HDR_BITS-1:0] HDR_WRITE = 4'b0101;
    localparam logic [HDR_BITS-1:0] HDR_READ  = 4'b0110;
    localparam logic [TA_BITS-1:0]  TA_WRITE  = 2'b10;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } mm_state_e;

    typedef struct packed {
        mm_state_e          state;
        logic               rd;
        logic [CNT_W-1:0]   bit_idx;
        logic               done;
        logic [DAT_W-1:0]   rdata;
    } mm_ctrl_t;

    function automatic logic [FRAME_BITS-1:0] compose_frame(
        input logic              rd,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  rg,
        input logic [DAT_W-1:0]  wd
    );
        logic [HDR_BITS-1:0] hdr;
        logic [TA_BITS-1:0]  ta;
        logic [DAT_W-1:0]    pay;
        hdr = rd ? HDR_READ : HDR_WRITE;
        ta  = rd ? {TA_BITS{1'b1}} : TA_WRITE;
        pay = rd ? {DAT_W{1'b1}} : wd;
        return {{PRE_BITS{1'b1}}, hdr, phy, rg, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);

    generate
        if (DIV <= 1) begin : g_half_rate
            logic mdc_d, mdc_q;

            always_comb begin
                mdc_d = run_i ? ~mdc_q : 1'b0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mdc_q <= 1'b0;
                else        mdc_q <= mdc_d;
            end

            assign mdc_o  = mdc_q;
            assign rise_o = run_i & ~mdc_q;
            assign fall_o = run_i &  mdc_q;
        end else begin : g_counted
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          mdc;
            } gen_t;

            gen_t gen_d, gen_q;
            logic wrap;

            always_comb begin
                gen_d = gen_q;
                wrap  = 1'b0;
                if (!run_i) begin
                    gen_d.cnt = '0;
                    gen_d.mdc = 1'b0;
                end else if (gen_q.cnt == LAST) begin
                    wrap      = 1'b1;
                    gen_d.cnt = '0;
                    gen_d.mdc = ~gen_q.mdc;
                end else begin
                    gen_d.cnt = gen_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) gen_q <= '0;
                else        gen_q <= gen_d;
            end

            assign mdc_o  = gen_q.mdc;
            assign rise_o = wrap & ~gen_q.mdc;
            assign fall_o = wrap &  gen_q.mdc;
        end
    endgenerate

endmodule

// File: rtl/mdio_shift_unit.sv
module mdio_shift_unit #(
    parameter int TX_W = 64,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TX_W-1:0] load_val_i,
    input  logic            shift_i,
    input  logic            cap_i,
    input  logic            cap_bit_i,
    output logic            tx_bit_o,
    output logic [RX_W-1:0] rx_o
);

    typedef struct packed {
        logic [TX_W-1:0] tx;
        logic [RX_W-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = load_val_i;
            sh_d.rx = '0;
        end else begin
            if (shift_i) sh_d.tx = {sh_q.tx[TX_W-2:0], 1'b0};
            if (cap_i)   sh_d.rx = {sh_q.rx[RX_W-2:0], cap_bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tx_bit_o = sh_q.tx[TX_W-1];
    assign rx_o     = sh_q.rx;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             read_i,
    input  logic [PHY_W-1:0] phy_addr_i,
    input  logic [REG_W-1:0] reg_addr_i,
    input  logic [DAT_W-1:0] wdata_i,
    output logic [DAT_W-1:0] rdata_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             mdc_o,
    output logic             mdio_o,
    output logic             mdio_oe_o,
    input  logic             mdio_i
);

    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] REL_BIT    = CNT_W'(RELEASE_IDX);
    localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(DATA_IDX);

    mm_ctrl_t ctl_d, ctl_q;

    logic                  running;
    logic                  tick_rise, tick_fall;
    logic                  do_load, do_shift, do_cap;
    logic                  tx_bit;
    logic [DAT_W-1:0]      rx_word;
    logic [FRAME_BITS-1:0] frame_word;

    assign running    = (ctl_q.state == ST_RUN);
    assign frame_word = compose_frame(read_i, phy_addr_i, reg_addr_i, wdata_i);

    mdio_mdc_gen #(
        .DIV (CLK_DIV)
    ) u_mdc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .mdc_o  (mdc_o),
        .rise_o (tick_rise),
        .fall_o (tick_fall)
    );

    mdio_shift_unit #(
        .TX_W (FRAME_BITS),
        .RX_W (DAT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (do_load),
        .load_val_i (frame_word),
        .shift_i    (do_shift),
        .cap_i      (do_cap),
        .cap_bit_i  (mdio_i),
        .tx_bit_o   (tx_bit),
        .rx_o       (rx_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        do_load    = 1'b0;
        do_shift   = 1'b0;
        do_cap     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    do_load       = 1'b1;
                    ctl_d.state   = ST_RUN;
                    ctl_d.rd      = read_i;
                    ctl_d.bit_idx = '0;
                end
            end
            ST_RUN: begin
                if (tick_rise && ctl_q.rd && (ctl_q.bit_idx >= FIRST_DATA)) begin
                    do_cap = 1'b1;
                end
                if (tick_fall) begin
                    if (ctl_q.bit_idx == LAST_BIT) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                        if (ctl_q.rd) ctl_d.rdata = rx_word;
                    end else begin
                        do_shift      = 1'b1;
                        ctl_d.bit_idx = ctl_q.bit_idx + 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mdio_oe_o = running & (~ctl_q.rd | (ctl_q.bit_idx < REL_BIT));
    assign mdio_o    = tx_bit & mdio_oe_o;
    assign busy_o    = running;
    assign done_o    = ctl_q.done;
    assign rdata_o   = ctl_q.rdata;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic read_i,
    input logic busy_o,
    input logic done_o,
    input logic mdc_o,
    input logic mdio_o,
    input logic mdio_oe_o
);

    localparam int HW = $clog2(DIV + 2) + 1;
    localparam logic [HW-1:0] HALF = HW'(DIV);

    logic [HW-1:0] hi_cnt, lo_cnt;
    logic [7:0]    pulse_cnt;
    logic          mdc_prev;
    logic          rd_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            pulse_cnt <= '0;
            mdc_prev  <= 1'b0;
            rd_lat    <= 1'b0;
        end else begin
            mdc_prev <= mdc_o;
            hi_cnt   <= mdc_o ? hi_cnt + 1'b1 : '0;
            lo_cnt   <= (busy_o && !mdc_o) ? lo_cnt + 1'b1 : '0;
            if (start_i && !busy_o) begin
                pulse_cnt <= '0;
                rd_lat    <= read_i;
            end else if (mdc_o && !mdc_prev) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdio_oe_o && !mdc_o)); // R1

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc_o) |-> (hi_cnt == HALF)); // R2

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> (lo_cnt == HALF)); // R2

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R3

    AST_FRAME_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pulse_cnt == 8'd64)); // R3

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rd_lat) |-> mdio_oe_o); // R5

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_lat && (pulse_cnt >= 8'd47)) |-> !mdio_oe_o); // R6

    AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R8

endmodule

bind mdio_master mdio_master_chk #(
    .DIV (CLK_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .read_i    (read_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int ntests = 0;
    int nfail  = 0;

    // main instance, CLK_DIV = 2
    logic        start = 1'b0, rd = 1'b0;
    logic [4:0]  phy = '0, rg = '0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic        busy, done, mdc, mdo, moe;
    wire         line;

    // fast instance, CLK_DIV = 1
    logic        f_start = 1'b0;
    logic [15:0] f_rdata;
    logic        f_busy, f_done, f_mdc, f_mdo, f_moe;

    mdio_master #(.CLK_DIV(2)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .read_i(rd),
        .phy_addr_i(phy), .reg_addr_i(rg), .wdata_i(wd),
        .rdata_o(rdata), .busy_o(busy), .done_o(done),
        .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(line)
    );

    mdio_master #(.CLK_DIV(1)) uut_fast (
        .clk(clk), .rst_n(rst_n), .start_i(f_start), .read_i(1'b0),
        .phy_addr_i(5'd3), .reg_addr_i(5'd4), .wdata_i(16'hC0DE),
        .rdata_o(f_rdata), .busy_o(f_busy), .done_o(f_done),
        .mdc_o(f_mdc), .mdio_o(f_mdo), .mdio_oe_o(f_moe), .mdio_i(1'b1)
    );

    // ---------------- PHY bus model: five PHYs, pull-up ----------------
    localparam logic [4:0] PHY_ADDR [5] = '{5'd0, 5'd3, 5'd9, 5'd17, 5'd31};
    logic [15:0] mem [5][32];
    logic        phy_oe = 1'b0, phy_d = 1'b1;
    logic [63:0] sr = '0, oe_sr = '0;
    int          pcnt = 0;
    int          contention = 0;
    int          slot_n;
    logic [3:0]  p_op = '0;
    logic [4:0]  p_phy = '0, p_reg = '0;

    assign line = moe ? mdo : (phy_oe ? phy_d : 1'b1);

    function automatic int phy_slot(input logic [4:0] a);
        for (int i = 0; i < 5; i++) if (PHY_ADDR[i] == a) return i;
        return -1;
    endfunction

    always @(posedge mdc) begin
        if (pcnt == 64) pcnt = 0;
        sr    = {sr[62:0], line};
        oe_sr = {oe_sr[62:0], moe};
        if (moe && phy_oe) contention++;
        pcnt++;
        if (pcnt == 46) begin
            p_op  = sr[13:10];
            p_phy = sr[9:5];
            p_reg = sr[4:0];
        end
    end

    always @(negedge mdc) begin
        slot_n = phy_slot(p_phy);
        if (pcnt == 47 && p_op == 4'b0110 && slot_n >= 0) begin
            phy_oe = 1'b1;
            phy_d  = 1'b0;
        end else if (pcnt >= 48 && pcnt <= 63 && phy_oe) begin
            phy_d = mem[slot_n][p_reg][63 - pcnt];
        end else if (pcnt == 64) begin
            phy_oe = 1'b0;
            phy_d  = 1'b1;
            if (p_op == 4'b0101 && slot_n >= 0) mem[slot_n][p_reg] = sr[15:0];
        end
    end

    // R8 watcher: line must not move while MDC stays high
    int   unstable = 0;
    logic prev_mdc = 1'b0, prev_mdo = 1'b0, prev_moe = 1'b0;
    always @(negedge clk) begin
        if (mdc && prev_mdc && (mdo !== prev_mdo || moe !== prev_moe)) unstable++;
        prev_mdc = mdc; prev_mdo = mdo; prev_moe = moe;
    end

    int f_rises = 0;
    always @(posedge f_mdc) f_rises++;

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    endtask

    int bc, dc;
    logic [15:0] last_rd = 16'h0000;

    // runs one frame on uut; if inject, a second start is pulsed mid-frame
    task automatic run_frame(input logic r, input logic [4:0] p, input logic [4:0] a,
                             input logic [15:0] w, input bit inject);
        int guard;
        @(negedge clk);
        start = 1'b1; rd = r; phy = p; rg = a; wd = w;
        @(negedge clk);
        start = 1'b0;
        bc = 0; dc = 0; guard = 0;
        while (busy && guard < 5000) begin
            bc++;
            if (inject && bc == 40) begin
                start = 1'b1; rd = 1'b1; phy = 5'd9; rg = 5'd7; wd = 16'h5555;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            dc += int'(done);
            guard++;
        end
        start = 1'b0;
    endtask

    localparam logic [42:0] VEC [13] = '{
        {1'b0, 5'd0,  5'd0,  16'hA5C3, 16'h0000},
        {1'b0, 5'd3,  5'd31, 16'h1234, 16'h0000},
        {1'b0, 5'd9,  5'd7,  16'hFFFF, 16'h0000},
        {1'b0, 5'd17, 5'd16, 16'h0000, 16'h0000},
        {1'b0, 5'd31, 5'd1,  16'h8001, 16'h0000},
        {1'b1, 5'd3,  5'd31, 16'h0000, 16'h1234},
        {1'b1, 5'd0,  5'd0,  16'h0000, 16'hA5C3},
        {1'b1, 5'd17, 5'd16, 16'h0000, 16'h0000},
        {1'b1, 5'd31, 5'd1,  16'h0000, 16'h8001},
        {1'b1, 5'd9,  5'd7,  16'h0000, 16'hFFFF},
        {1'b1, 5'd5,  5'd2,  16'h0000, 16'hFFFF},
        {1'b0, 5'd3,  5'd31, 16'h0F0F, 16'h0000},
        {1'b1, 5'd3,  5'd31, 16'h0000, 16'h0F0F}
    };

    initial begin
        repeat (150000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy",  64'(busy),  64'd0);
        chk("R1", "done",  64'(done),  64'd0);
        chk("R1", "mdc",   64'(mdc),   64'd0);
        chk("R1", "oe",    64'(moe),   64'd0);
        chk("R1", "rdata", 64'(rdata), 64'd0);
        chk("R1", "fast idle", 64'({f_busy, f_mdc, f_moe}), 64'd0);

        for (int i = 0; i < 13; i++) begin
            logic        vr;
            logic [4:0]  vp, va;
            logic [15:0] vw, ve;
            {vr, vp, va, vw, ve} = VEC[i];
            run_frame(vr, vp, va, vw, 1'b0);
            chk("R2", "busy cycles", 64'(bc), 64'd256);
            chk("R3", "done count", 64'(dc), 64'd1);
            chk("R3", "mdc pulses", 64'(pcnt), 64'd64);
            chk("R1", "idle after frame", 64'({busy, mdc, moe}), 64'd0);
            if (!vr) begin
                chk("R5", "write bits", sr, {32'hFFFF_FFFF, 4'b0101, vp, va, 2'b10, vw});
                chk("R5", "write oe", oe_sr, 64'hFFFF_FFFF_FFFF_FFFF);
                chk("R10", "rdata held", 64'(rdata), 64'(last_rd));
            end else begin
                chk("R4", "preamble", 64'(sr[63:32]), 64'hFFFF_FFFF);
                chk("R6", "read header", 64'(sr[31:18]), 64'({4'b0110, vp, va}));
                chk("R6", "read oe", oe_sr, 64'hFFFF_FFFF_FFFC_0000);
                chk("R9", "read data", 64'(rdata), 64'(ve));
                last_rd = ve;
            end
            @(negedge clk);
            chk("R3", "done one cycle", 64'(done), 64'd0);
        end

        // R7: start during busy ignored
        run_frame(1'b0, 5'd0, 5'd5, 16'h1111, 1'b1);
        chk("R7", "busy cycles", 64'(bc), 64'd256);
        chk("R7", "bits of first frame", sr, {32'hFFFF_FFFF, 4'b0101, 5'd0, 5'd5, 2'b10, 16'h1111});
        repeat (20) @(negedge clk);
        chk("R7", "no queued frame", 64'({busy, 8'(pcnt)}), 64'd64);
        chk("R10", "rdata after write", 64'(rdata), 64'(last_rd));
        run_frame(1'b1, 5'd0, 5'd5, 16'h0000, 1'b0);
        chk("R7", "write landed", 64'(rdata), 64'h1111);

        chk("R8", "line stable while high", 64'(unstable), 64'd0);
        chk("R6", "no contention", 64'(contention), 64'd0);

        // R2 at the fastest rate, CLK_DIV = 1
        begin
            int fr0, fbc, fdc, fhi;
            fr0 = f_rises;
            @(negedge clk); f_start = 1'b1;
            @(negedge clk); f_start = 1'b0;
            fbc = 0; fdc = 0; fhi = 0;
            for (int g = 0; g < 1000 && f_busy; g++) begin
                fbc++;
                fhi += int'(f_mdc);
                @(negedge clk);
                fdc += int'(f_done);
            end
            chk("R2", "fast busy cycles", 64'(fbc), 64'd128);
            chk("R2", "fast high cycles", 64'(fhi), 64'd64);
            chk("R3", "fast pulses", 64'(f_rises - fr0), 64'd64);
            chk("R3", "fast done", 64'(fdc), 64'd1);
        end

        summary();
        $finish;
    end

endmodule